// File: doc/BRIEF.md
# Execute Stage: ALU, Flags and Condition Evaluation

This block is the execute step of a simple single-cycle processor. From the decoded opcode it picks the two ALU operands. The candidates are the two register values, the instruction constant, and the stack adjustments −4 and +4. It then picks the ALU function and produces the result `val_e` in the same cycle.

A three-bit flag register holds zero, sign and overflow. It loads on the rising clock edge, and only when a valid arithmetic instruction is present. One condition evaluator reads the stored flags and the function code. Jumps and conditional moves both use it, and its output is `cnd`.

The surrounding datapath uses `val_e` as a register write value or a memory address. It uses `cnd` to choose the next PC or to qualify a register move. Memory access and register writes happen outside this block.

Top module: `exe_stage`

## Requirements
- R1: While `rst_n` is low at a rising edge, the flags are set to zero=1, sign=0 and overflow=0. After reset, a jump with function 3 (equal) therefore gives `cnd`=1, and a jump with function 2 (less) gives `cnd`=0.
- R2: Operand A depends on the opcode:
  - `val_a` for opcode 2 (register move) and opcode 6 (arithmetic);
  - `val_c` for opcode 3 (immediate move), opcode 4 (store) and opcode 5 (load);
  - −4 for opcode 8 (call) and opcode 10 (push);
  - +4 for opcode 9 (return) and opcode 11 (pop).
- R3: Operand B is zero for opcodes 2 and 3, and `val_b` for opcodes 4, 5, 6, 8, 9, 10 and 11.
- R4: For opcode 6, the function code selects B+A (0), B−A (1), B&A (2) or B^A (3). Every other opcode, and opcode 6 with a function code above 3, uses addition.
- R5: For opcodes 0, 1, 7 and 12 to 15, `val_e` is 0.
- R6: The flags change only at a rising edge where the opcode is 6 and the function code is below 4. Every other cycle leaves them unchanged.
- R7: On a load, zero is set when the result is all zeros, and sign takes the result's top bit.
- R8: On a load, overflow is set in two cases. For addition, both operands have the same sign and the result's sign differs from it. For subtraction B−A, the operand signs differ and the result's sign differs from B. Overflow is cleared for AND and XOR.
- R9: With lt = sign^overflow, the conditions are:
  - 0 = always;
  - 1 = lt | zero;
  - 2 = lt;
  - 3 = zero;
  - 4 = !zero;
  - 5 = !lt;
  - 6 = !lt & !zero.

  Function 0 on opcode 2 is therefore an unconditional move.
- R10: `cnd` is 0 for every opcode other than 2 and 7, and for function codes 7 to 15.
- R11: `cnd` uses the flags stored before the current cycle's edge. An arithmetic instruction affects `cnd` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 4 | Instruction code of the current instruction |
| func | input | 4 | Function code: ALU operation or condition |
| val_a | input | W | First register operand |
| val_b | input | W | Second register operand |
| val_c | input | W | Instruction constant |
| val_e | output | W | ALU result |
| cnd | output | 1 | Jump-taken / move-enable flag |

## Verification
Two functions can fall in the same cycle. The flag register can load at an edge while `cnd` is being evaluated from the flags stored before that edge. A conditional move can also pass `val_a` through to `val_e` while its own condition is evaluated.

The bench provokes the first case with arithmetic instructions placed directly before jumps and moves. Each of these produces a carry into the sign bit, a zero result or a signed overflow. The bench then checks that `cnd` follows the older flags in the arithmetic cycle and the new flags in the next cycle.

The bench judges both `val_e` and `cnd` against a behavioural model on every cycle. The model keeps its own flag copy and updates it after each edge.

// File: rtl/exe_pkg.sv
// Package: shared opcode and function constants and the flag record for the
// execute stage. Assumes 4-bit opcode and function fields.
package exe_pkg;

    localparam logic [3:0] OPC_HALT  = 4'h0;
    localparam logic [3:0] OPC_NOP   = 4'h1;
    localparam logic [3:0] OPC_MOVE  = 4'h2;
    localparam logic [3:0] OPC_IMOV  = 4'h3;
    localparam logic [3:0] OPC_STORE = 4'h4;
    localparam logic [3:0] OPC_LOAD  = 4'h5;
    localparam logic [3:0] OPC_ARITH = 4'h6;
    localparam logic [3:0] OPC_JUMP  = 4'h7;
    localparam logic [3:0] OPC_CALL  = 4'h8;
    localparam logic [3:0] OPC_RET   = 4'h9;
    localparam logic [3:0] OPC_PUSH  = 4'hA;
    localparam logic [3:0] OPC_POP   = 4'hB;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_XOR = 2'd3
    } alu_fn_e;

    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_VALA,
        SRC_VALB,
        SRC_VALC,
        SRC_MINUS4,
        SRC_PLUS4
    } src_sel_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/exe_operand_sel.sv
// Module: exe_operand_sel
// Chooses the two ALU operands from the opcode through a per-opcode table.
// Assumes: opcodes that do not use the ALU get zero on both sides, so their
// result is zero.
module exe_operand_sel
    import exe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   opcode,
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic [W-1:0] val_c,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b
);
    localparam logic [W-1:0] STEP = W'(4);

    src_sel_e sel_a;
    src_sel_e sel_b;

    // Table: opcode to operand source selections
    always_comb begin
        sel_a = SRC_ZERO;
        sel_b = SRC_ZERO;
        unique case (opcode)
            OPC_MOVE:                  begin sel_a = SRC_VALA;   sel_b = SRC_ZERO; end
            OPC_ARITH:                 begin sel_a = SRC_VALA;   sel_b = SRC_VALB; end
            OPC_IMOV:                  begin sel_a = SRC_VALC;   sel_b = SRC_ZERO; end
            OPC_STORE, OPC_LOAD:       begin sel_a = SRC_VALC;   sel_b = SRC_VALB; end
            OPC_CALL, OPC_PUSH:        begin sel_a = SRC_MINUS4; sel_b = SRC_VALB; end
            OPC_RET, OPC_POP:          begin sel_a = SRC_PLUS4;  sel_b = SRC_VALB; end
            default:                   begin sel_a = SRC_ZERO;   sel_b = SRC_ZERO; end
        endcase
    end

    // Mux: operand A from its selection
    always_comb begin
        unique case (sel_a)
            SRC_VALA:   op_a = val_a;
            SRC_VALC:   op_a = val_c;
            SRC_MINUS4: op_a = -STEP;
            SRC_PLUS4:  op_a = STEP;
            default:    op_a = '0;
        endcase
    end

    // Mux: operand B from its selection
    always_comb begin
        unique case (sel_b)
            SRC_VALB: op_b = val_b;
            default:  op_b = '0;
        endcase
    end

    // R3: a zero-B opcode must not see val_b
    always_comb begin
        if (opcode == OPC_MOVE || opcode == OPC_IMOV)
            assert_zero_b_R3: assert (op_b == '0);
    end

endmodule

// File: rtl/exe_alu.sv
// Module: exe_alu
// Computes B op A for add, subtract, and, xor, and the flag values that this
// result would load. Assumes two's complement operands of width W.
module exe_alu
    import exe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  alu_fn_e      fn,
    output logic [W-1:0] result,
    output flags_t       next_flags
);
    localparam int MSB = W - 1;

    // Datapath: the selected operation
    always_comb begin
        unique case (fn)
            ALU_ADD: result = op_b + op_a;
            ALU_SUB: result = op_b - op_a;
            ALU_AND: result = op_b & op_a;
            ALU_XOR: result = op_b ^ op_a;
            default: result = '0;
        endcase
    end

    // Flags: zero, sign and signed overflow of the result
    always_comb begin
        next_flags.zf = (result == '0);
        next_flags.sf = result[MSB];
        unique case (fn)
            ALU_ADD: next_flags.of = (op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB]);
            ALU_SUB: next_flags.of = (op_a[MSB] != op_b[MSB]) && (result[MSB] != op_b[MSB]);
            default: next_flags.of = 1'b0;
        endcase
    end

endmodule

// File: rtl/exe_cond_flags.sv
// Module: exe_cond_flags
// Holds the three flags and evaluates the shared condition for jumps and
// conditional moves. Assumes the load enable is already qualified by opcode.
module exe_cond_flags
    import exe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  flags_t     next_flags,
    input  logic [3:0] opcode,
    input  logic [3:0] func,
    output flags_t     flags,
    output logic       cnd
);
    logic lt;
    logic hit;

    // Register: flags, synchronous reset, load on arithmetic only
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= FLAGS_RESET;
        else if (load)
            flags <= next_flags;
    end

    // Evaluate: the seven-way condition from the stored flags
    always_comb begin
        lt = flags.sf ^ flags.of;
        unique case (func)
            4'd0:    hit = 1'b1;
            4'd1:    hit = lt | flags.zf;
            4'd2:    hit = lt;
            4'd3:    hit = flags.zf;
            4'd4:    hit = !flags.zf;
            4'd5:    hit = !lt;
            4'd6:    hit = !lt & !flags.zf;
            default: hit = 1'b0;
        endcase
    end

    // Gate: only jump and move opcodes report a condition
    assign cnd = hit && (opcode == OPC_MOVE || opcode == OPC_JUMP);

    assert_reset_flags_R1: assert property (@(posedge clk)
        !rst_n |=> (flags == FLAGS_RESET));

    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags));

    assert_cnd_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OPC_MOVE && opcode != OPC_JUMP) |-> !cnd);

endmodule

// File: rtl/exe_stage.sv
// Module: exe_stage (top)
// Execute stage: operand selection, ALU, flag register and condition
// evaluation. Assumes a synchronous active-low reset and that the caller
// holds inputs steady around the rising edge.
module exe_stage
    import exe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   opcode,
    input  logic [3:0]   func,
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic [W-1:0] val_c,
    output logic [W-1:0] val_e,
    output logic         cnd
);
    localparam int MSB = W - 1;

    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    alu_fn_e      alu_fn;
    flags_t       alu_flags;
    flags_t       cur_flags;
    logic         flag_load;

    // Control: arithmetic with a valid function code picks the ALU op and loads flags
    always_comb begin
        flag_load = (opcode == OPC_ARITH) && (func < 4'd4);
        alu_fn    = flag_load ? alu_fn_e'(func[1:0]) : ALU_ADD;
    end

    exe_operand_sel #(.W(W)) u_sel (
        .opcode (opcode),
        .val_a  (val_a),
        .val_b  (val_b),
        .val_c  (val_c),
        .op_a   (op_a),
        .op_b   (op_b)
    );

    exe_alu #(.W(W)) u_alu (
        .op_a       (op_a),
        .op_b       (op_b),
        .fn         (alu_fn),
        .result     (val_e),
        .next_flags (alu_flags)
    );

    exe_cond_flags u_cc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (flag_load),
        .next_flags (alu_flags),
        .opcode     (opcode),
        .func       (func),
        .flags      (cur_flags),
        .cnd        (cnd)
    );

    assert_stack_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_PUSH || opcode == OPC_CALL) |-> (val_e == val_b - W'(4)));

    assert_and_fn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_ARITH && func == 4'd2) |-> (val_e == (val_b & val_a)));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_JUMP || opcode == OPC_NOP || opcode == OPC_HALT) |-> (val_e == '0));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> (cur_flags.zf == ($past(val_e) == '0)));

    assert_add_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_load && func == 4'd0 && val_a[MSB] == val_b[MSB] && val_e[MSB] != val_a[MSB])
        |=> cur_flags.of);

endmodule

// File: tb/sim_exe_stage.sv
module sim_exe_stage;
    localparam int PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   opcode = 4'h1;
    logic [3:0]   func = 4'h0;
    logic [W-1:0] val_a = '0;
    logic [W-1:0] val_b = '0;
    logic [W-1:0] val_c = '0;
    logic [W-1:0] val_e;
    logic         cnd;

    int checks = 0;
    int errors = 0;
    bit m_zf = 1'b1;
    bit m_sf = 1'b0;
    bit m_of = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    exe_stage #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .func(func),
        .val_a(val_a), .val_b(val_b), .val_c(val_c),
        .val_e(val_e), .cnd(cnd)
    );

    function automatic logic [W-1:0] model_e(input logic [3:0] o, input logic [3:0] f,
                                             input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [W-1:0] c);
        case (o)
            4'h2: return a;
            4'h3: return c;
            4'h4, 4'h5: return b + c;
            4'h6: case (f)
                      4'd1: return b - a;
                      4'd2: return b & a;
                      4'd3: return b ^ a;
                      default: return b + a;
                  endcase
            4'h8, 4'hA: return b - 32'd4;
            4'h9, 4'hB: return b + 32'd4;
            default: return '0;
        endcase
    endfunction

    function automatic bit model_c(input logic [3:0] o, input logic [3:0] f);
        bit lt;
        lt = m_sf ^ m_of;
        if (o != 4'h2 && o != 4'h7) return 1'b0;
        case (f)
            4'd0: return 1'b1;
            4'd1: return lt | m_zf;
            4'd2: return lt;
            4'd3: return m_zf;
            4'd4: return !m_zf;
            4'd5: return !lt;
            4'd6: return !lt && !m_zf;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] exp_e, input bit exp_c);
        checks++;
        if (val_e !== exp_e) begin
            errors++;
            $display("FAIL %s val_e actual %h expected %h (op %h fn %h)", tag, val_e, exp_e, opcode, func);
        end
        checks++;
        if (cnd !== exp_c) begin
            errors++;
            $display("FAIL %s cnd actual %b expected %b (op %h fn %h)", tag, cnd, exp_c, opcode, func);
        end
    endtask

    // One instruction: drive at negedge, check before the edge, update model after it
    task automatic step(input string tag, input logic [3:0] o, input logic [3:0] f,
                        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] r;
        @(negedge clk);
        opcode = o; func = f; val_a = a; val_b = b; val_c = c;
        #1;
        r = model_e(o, f, a, b, c);
        check(tag, r, model_c(o, f));
        @(posedge clk);
        if (o == 4'h6 && f < 4'd4) begin   // R6 load only on valid arithmetic
            m_zf = (r == '0);
            m_sf = r[W-1];
            if (f == 4'd0)      m_of = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            else if (f == 4'd1) m_of = (a[W-1] != b[W-1]) && (r[W-1] != b[W-1]);
            else                m_of = 1'b0;
        end
    endtask

    task automatic sweep_conds(input string tag);
        for (int k = 0; k < 8; k++) step(tag, 4'h7, 4'(k), 32'h0, 32'h0, 32'h0);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset flags seen through conditions; R10 fn 7 gives 0
        sweep_conds("R1_R9_R10");
        // R2 R3 operand table
        step("R2_R3_move",  4'h2, 4'h0, 32'h1234, 32'h99, 32'h55);
        step("R2_R3_imov",  4'h3, 4'h0, 32'h1234, 32'h99, 32'h55);
        step("R2_store",    4'h4, 4'h0, 32'h1, 32'h100, 32'h20);
        step("R2_load",     4'h5, 4'h0, 32'h1, 32'h100, 32'hFFFF_FFF0);
        step("R2_call",     4'h8, 4'h0, 32'h7, 32'h200, 32'h9);
        step("R2_push",     4'hA, 4'h0, 32'h7, 32'h200, 32'h9);
        step("R2_ret",      4'h9, 4'h0, 32'h7, 32'h200, 32'h9);
        step("R2_pop",      4'hB, 4'h0, 32'h7, 32'h200, 32'h9);
        // R5 idle opcodes give zero
        step("R5_halt",     4'h0, 4'h0, 32'h7, 32'h200, 32'h9);
        step("R5_nop",      4'h1, 4'h3, 32'h7, 32'h200, 32'h9);
        step("R5_op_c",     4'hC, 4'h0, 32'h7, 32'h200, 32'h9);
        // R8 add overflow positive, then R11 condition sweep sees new flags
        step("R4_R8_add_ovf", 4'h6, 4'h0, 32'h7FFF_FFFF, 32'h1, 32'h0);
        sweep_conds("R9_R11_after_ovf");
        // R7 zero result
        step("R4_R7_sub_zero", 4'h6, 4'h1, 32'h55, 32'h55, 32'h0);
        sweep_conds("R7_R9_zero");
        // R7 negative result, no overflow
        step("R4_R7_sub_neg", 4'h6, 4'h1, 32'h10, 32'h5, 32'h0);
        sweep_conds("R7_R9_neg");
        // R8 subtract overflow: B negative minus positive
        step("R8_sub_ovf", 4'h6, 4'h1, 32'h1, 32'h8000_0000, 32'h0);
        sweep_conds("R8_R9_subovf");
        // R4 and/xor clear overflow
        step("R4_R8_and", 4'h6, 4'h2, 32'hF0F0_0000, 32'hFF00_0000, 32'h0);
        sweep_conds("R8_and_clear");
        step("R4_xor", 4'h6, 4'h3, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0);
        // R6 invalid arith fn: adds but no load; R11 the next jump sees old flags
        step("R4_R6_bad_fn", 4'h6, 4'h9, 32'hFFFF_FFFF, 32'h1, 32'h0);
        step("R6_hold", 4'h7, 4'h3, 32'h0, 32'h0, 32'h0);
        step("R6_store_hold", 4'h4, 4'h0, 32'h0, 32'h0, 32'h0);
        step("R6_hold2", 4'h7, 4'h3, 32'h0, 32'h0, 32'h0);
        // R9 conditional moves
        for (int k = 0; k < 8; k++) step("R9_R10_cmov", 4'h2, 4'(k), 32'hABCD, 32'h1, 32'h2);
        // Mixed random stream
        for (int n = 0; n < 600; n++)
            step("R2_R4_R9_rand", 4'($urandom_range(0, 15)), 4'($urandom_range(0, 7)),
                 ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom(),
                 ($urandom_range(0, 3) == 0) ? 32'h7FFF_FFFF : $urandom(), $urandom());
        // R1 reset again restores flags
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_zf = 1'b1; m_sf = 1'b0; m_of = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        sweep_conds("R1_rereset");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule